// File: doc/BRIEF.md
# Predicated Odd-Lane Float Widener

This block takes one fixed-width vector of packed narrow floating-point values and widens the odd-numbered narrow elements into floating-point values twice as wide. Each odd element lies in the upper half of a wide lane. The block runs in one of two modes: 16-bit to 32-bit values, or 32-bit to 64-bit values. A per-byte predicate selects which wide lanes are written. Lanes that are not selected keep the value of the old destination vector that the caller supplies. The merged full-width vector comes out one clock after the input strobe.

A wider format can represent every narrow value exactly, so no rounding takes place. Narrow subnormals are either normalised into the wider format or flushed to signed zero. Signalling NaNs are quieted. A default-NaN control replaces every NaN output with one canonical quiet NaN. Two sticky exception flags collect the events seen in active lanes and stay set until a clear input is pulsed.

Top module: `fpw_widen_odd`

## Requirements
- R1: Wide lane e is converted from narrow element 2e+1 of `src_vec`. This is the upper half of the wide lane: bits [32e+31:32e+16] in mode 0 and bits [64e+63:64e+32] in mode 1. Even narrow elements have no effect on the result or on the flags.
- R2: `cvt_mode`=0 converts binary16 to binary32 in 32-bit lanes. `cvt_mode`=1 converts binary32 to binary64 in 64-bit lanes.
- R3: A wide lane is active when the predicate bit of its lowest byte is set: `pred_mask[4e]` in mode 0 and `pred_mask[8e]` in mode 1. An inactive lane returns the matching bits of `dst_old`. All other predicate bits are ignored.
- R4: A normal input keeps its sign. Its exponent is rebiased (+112 for mode 0, +896 for mode 1). Its fraction is placed at the top of the wider fraction with zero fill. Zeros and infinities keep their sign.
- R5: When `flush_den`=0, a subnormal input is normalised into an exact normal wide value. For example, binary16 0x0001 becomes 0x33800000.
- R6: When `flush_den`=1, a subnormal input becomes a zero of the same sign and raises the input-denormal flag.
- R7: A NaN keeps its sign, and its payload is moved to the top of the wider fraction. A signalling NaN (fraction MSB 0) gets its fraction MSB set and raises the invalid flag.
- R8: When `dflt_nan`=1, every NaN input produces the canonical quiet NaN: sign 0, exponent all ones, only the fraction MSB set. A signalling input still raises the invalid flag.
- R9: Only active lanes contribute to the flags. The flags are sticky. `flag_clr` clears them, and contributions from the same cycle are applied after the clear.
- R10: `res_valid` is high exactly one cycle after `in_valid`. `res_vec` changes only in that cycle and otherwise holds its value.
- R11: After reset, `res_valid`, `res_vec`, `flag_inv` and `flag_den` are all zero.
- R12: An accepted vector with no active lane returns `dst_old` unchanged and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| cvt_mode | input | 1 | 0: 16→32, 1: 32→64 |
| flush_den | input | 1 | Flush subnormal inputs to zero |
| dflt_nan | input | 1 | Force canonical NaN outputs |
| flag_clr | input | 1 | Clear the sticky flags |
| src_vec | input | VEC_W | Packed narrow source vector |
| dst_old | input | VEC_W | Previous destination value |
| pred_mask | input | VEC_W/8 | One predicate bit per byte |
| res_valid | output | 1 | Result valid strobe |
| res_vec | output | VEC_W | Merged result vector |
| flag_inv | output | 1 | Sticky invalid-operation flag |
| flag_den | output | 1 | Sticky input-denormal flag |

## Verification
A wrong lane index or predicate tap appears as a wrong wide lane in `res_vec` on the strobe cycle right after the input, usually together with a flag raised by a lane that should have been ignored. A corrupted sticky flag register shows on `flag_inv` or `flag_den` at the next accepted vector or clear, and it stays wrong until the next clear. A stale result register shows when `res_vec` moves in a cycle without `res_valid`.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    typedef enum logic {
        CVT_H2S = 1'b0,
        CVT_S2D = 1'b1
    } cvt_mode_e;

    typedef struct packed {
        logic invalid;
        logic denorm;
    } fp_flags_t;

endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
    parameter int W  = 10,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] zeros
);

    // The highest set bit decides the count; the scan runs upward so it wins.
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) zeros = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/fpw_lane.sv
module fpw_lane
    import fpw_pkg::*;
#(
    parameter int NE = 5,
    parameter int NM = 10,
    parameter int WE = 8,
    parameter int WM = 23,
    localparam int NW = 1 + NE + NM,
    localparam int WW = 1 + WE + WM
) (
    input  logic [NW-1:0] nar_i,
    input  logic          flush_i,
    input  logic          dnan_i,
    output logic [WW-1:0] wide_o,
    output fp_flags_t     flags_o
);

    localparam int NBIAS  = (1 << (NE - 1)) - 1;
    localparam int WBIAS  = (1 << (WE - 1)) - 1;
    localparam int REBIAS = WBIAS - NBIAS;
    localparam int PAD    = WM - NM;
    localparam int CW     = $clog2(NM + 1);

    logic          sgn;
    logic [NE-1:0] nexp;
    logic [NM-1:0] man;
    logic [CW-1:0] lz;
    logic [NM-1:0] sub_man;
    logic [WE-1:0] sub_exp;
    logic [WE-1:0] nrm_exp;

    assign sgn  = nar_i[NW-1];
    assign nexp = nar_i[NW-2 -: NE];
    assign man  = nar_i[NM-1:0];

    fpw_lzc #(.W(NM)) u_lzc (
        .din   (man),
        .zeros (lz)
    );

    // Subnormal: shift the leading one out, lower the exponent by the shift.
    assign sub_man = man << (lz + 1'b1);
    assign sub_exp = WE'(REBIAS) - WE'(lz);
    assign nrm_exp = WE'(nexp) + WE'(REBIAS);

    always_comb begin
        wide_o  = '0;
        flags_o = '0;
        if (nexp == '0) begin
            if (man == '0) begin
                wide_o = {sgn, {(WW-1){1'b0}}};
            end else if (flush_i) begin
                wide_o         = {sgn, {(WW-1){1'b0}}};
                flags_o.denorm = 1'b1;
            end else begin
                wide_o = {sgn, sub_exp, sub_man, {PAD{1'b0}}};
            end
        end else if (&nexp) begin
            if (man == '0) begin
                wide_o = {sgn, {WE{1'b1}}, {WM{1'b0}}};
            end else begin
                flags_o.invalid = ~man[NM-1];
                if (dnan_i) begin
                    wide_o = {1'b0, {WE{1'b1}}, 1'b1, {(WM-1){1'b0}}};
                end else begin
                    wide_o = {sgn, {WE{1'b1}}, 1'b1, man[NM-2:0], {PAD{1'b0}}};
                end
            end
        end else begin
            wide_o = {sgn, nrm_exp, man, {PAD{1'b0}}};
        end
    end

endmodule

// File: rtl/fpw_widen_odd.sv
module fpw_widen_odd
    import fpw_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               cvt_mode,
    input  logic               flush_den,
    input  logic               dflt_nan,
    input  logic               flag_clr,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   dst_old,
    input  logic [VEC_W/8-1:0] pred_mask,
    output logic               res_valid,
    output logic [VEC_W-1:0]   res_vec,
    output logic               flag_inv,
    output logic               flag_den
);

    localparam int N32 = VEC_W / 32;
    localparam int N64 = VEC_W / 64;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        fp_flags_t        flags;
    } state_t;

    state_t st_d, st_q;

    cvt_mode_e        mode;
    logic             act_h, act_d, any_act;
    logic [VEC_W-1:0] src_eff;

    logic [31:0] h_res [N32];
    fp_flags_t   h_flg [N32];
    logic [63:0] d_res [N64];
    fp_flags_t   d_flg [N64];

    assign mode = cvt_mode_e'(cvt_mode);

    // Lane activity: only the lowest-byte predicate bit of each wide lane counts.
    always_comb begin
        act_h = 1'b0;
        act_d = 1'b0;
        for (int i = 0; i < N32; i++) act_h |= pred_mask[4*i];
        for (int i = 0; i < N64; i++) act_d |= pred_mask[8*i];
        any_act = (mode == CVT_S2D) ? act_d : act_h;
    end

    // With nothing active the converters see zeros and stay quiet.
    assign src_eff = any_act ? src_vec : '0;

    for (genvar g = 0; g < N32; g++) begin : g_h2s
        fpw_lane #(.NE(5), .NM(10), .WE(8), .WM(23)) u_lane (
            .nar_i   (src_eff[32*g+16 +: 16]),
            .flush_i (flush_den),
            .dnan_i  (dflt_nan),
            .wide_o  (h_res[g]),
            .flags_o (h_flg[g])
        );
    end

    for (genvar g = 0; g < N64; g++) begin : g_s2d
        fpw_lane #(.NE(8), .NM(23), .WE(11), .WM(52)) u_lane (
            .nar_i   (src_eff[64*g+32 +: 32]),
            .flush_i (flush_den),
            .dnan_i  (dflt_nan),
            .wide_o  (d_res[g]),
            .flags_o (d_flg[g])
        );
    end

    always_comb begin
        logic [VEC_W-1:0] merged;
        fp_flags_t        new_flg;

        merged  = dst_old;
        new_flg = '0;
        if (mode == CVT_H2S) begin
            for (int i = 0; i < N32; i++) begin
                if (pred_mask[4*i]) begin
                    merged[32*i +: 32] = h_res[i];
                    new_flg            = new_flg | h_flg[i];
                end
            end
        end else begin
            for (int i = 0; i < N64; i++) begin
                if (pred_mask[8*i]) begin
                    merged[64*i +: 64] = d_res[i];
                    new_flg            = new_flg | d_flg[i];
                end
            end
        end

        st_d       = st_q;
        st_d.valid = in_valid;
        if (flag_clr) st_d.flags = '0;
        if (in_valid) begin
            st_d.vec   = merged;
            st_d.flags = st_d.flags | new_flg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_vec   = st_q.vec;
    assign flag_inv  = st_q.flags.invalid;
    assign flag_den  = st_q.flags.denorm;

endmodule

// File: rtl/fpw_checks.sv
module fpw_checks #(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               flag_clr,
    input logic [VEC_W/8-1:0] pred_mask,
    input logic [VEC_W-1:0]   dst_old,
    input logic               res_valid,
    input logic [VEC_W-1:0]   res_vec,
    input logic               flag_inv,
    input logic               flag_den
);

    a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    a_r10_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_vec));

    a_r9_inv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_inv && !flag_clr) |=> flag_inv);

    a_r9_den_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_den && !flag_clr) |=> flag_den);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> (!flag_inv && !flag_den));

    a_r12_empty_pred_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_mask == '0) |=> (res_vec == $past(dst_old)));

    a_r12_empty_pred_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred_mask == '0 && !flag_clr) |=> ($stable(flag_inv) && $stable(flag_den)));

endmodule

bind fpw_widen_odd fpw_checks #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .flag_clr  (flag_clr),
    .pred_mask (pred_mask),
    .dst_old   (dst_old),
    .res_valid (res_valid),
    .res_vec   (res_vec),
    .flag_inv  (flag_inv),
    .flag_den  (flag_den)
);

// File: tb/sim_fpw_widen_odd.sv
`timescale 1ns/1ps
module sim_fpw_widen_odd;

    localparam int VW = 128;
    localparam int PW = VW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          cvt_mode = 1'b0;
    logic          flush_den = 1'b0;
    logic          dflt_nan = 1'b0;
    logic          flag_clr = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] dst_old = '0;
    logic [PW-1:0] pred_mask = '0;
    logic          res_valid;
    logic [VW-1:0] res_vec;
    logic          flag_inv;
    logic          flag_den;

    int n_chk = 0;
    int n_bad = 0;
    logic m_inv = 1'b0;
    logic m_den = 1'b0;

    always #2.5 clk = ~clk;

    fpw_widen_odd #(.VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cvt_mode(cvt_mode),
        .flush_den(flush_den), .dflt_nan(dflt_nan), .flag_clr(flag_clr),
        .src_vec(src_vec), .dst_old(dst_old), .pred_mask(pred_mask),
        .res_valid(res_valid), .res_vec(res_vec), .flag_inv(flag_inv), .flag_den(flag_den)
    );

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent scalar model of one widening conversion.
    function automatic logic [63:0] ref_cvt(input logic md, input logic [31:0] n,
                                            input logic fz, input logic dn,
                                            output logic inv, output logic den);
        int ne, nm, we, wm, nb, wb, e;
        logic [63:0] m, s, ones, r;
        ne = md ? 8 : 5;   nm = md ? 23 : 10;
        we = md ? 11 : 8;  wm = md ? 52 : 23;
        nb = (1 << (ne - 1)) - 1;
        wb = (1 << (we - 1)) - 1;
        s    = 64'(n >> (ne + nm)) & 64'd1;
        e    = int'((n >> nm) & ((32'd1 << ne) - 1));
        m    = 64'(n) & ((64'd1 << nm) - 1);
        ones = (64'd1 << we) - 1;
        inv = 1'b0;
        den = 1'b0;
        if (e == 0 && m == 0) begin
            r = s << (we + wm);
        end else if (e == 0) begin
            if (fz) begin
                r   = s << (we + wm);
                den = 1'b1;
            end else begin
                e = 1;
                while (((m >> nm) & 64'd1) == 0) begin
                    m = m << 1;
                    e = e - 1;
                end
                m = m & ((64'd1 << nm) - 1);
                r = (s << (we + wm)) | (64'(e - nb + wb) << wm) | (m << (wm - nm));
            end
        end else if (e == (1 << ne) - 1) begin
            if (m == 0) begin
                r = (s << (we + wm)) | (ones << wm);
            end else begin
                inv = ((m >> (nm - 1)) & 64'd1) == 0;
                if (dn) r = (ones << wm) | (64'd1 << (wm - 1));
                else    r = (s << (we + wm)) | (ones << wm) | (m << (wm - nm)) | (64'd1 << (wm - 1));
            end
        end else begin
            r = (s << (we + wm)) | (64'(e - nb + wb) << wm) | (m << (wm - nm));
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic md, input logic [VW-1:0] s,
                                              input logic [VW-1:0] o, input logic [PW-1:0] p,
                                              input logic fz, input logic dn,
                                              output logic inv, output logic den);
        logic [VW-1:0] r;
        logic [63:0] w;
        logic li, ld;
        r = o; inv = 1'b0; den = 1'b0;
        if (!md) begin
            for (int e = 0; e < VW / 32; e++) begin
                if (p[4*e]) begin
                    w = ref_cvt(1'b0, {16'h0, s[32*e+16 +: 16]}, fz, dn, li, ld);
                    r[32*e +: 32] = w[31:0];
                    inv |= li; den |= ld;
                end
            end
        end else begin
            for (int e = 0; e < VW / 64; e++) begin
                if (p[8*e]) begin
                    w = ref_cvt(1'b1, s[64*e+32 +: 32], fz, dn, li, ld);
                    r[64*e +: 64] = w;
                    inv |= li; den |= ld;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] pick(input logic md);
        logic [31:0] r;
        logic sg;
        int k;
        k  = int'($urandom % 8);
        sg = 1'($urandom);
        r  = $urandom;
        if (!md) begin
            case (k)
                0: r = {16'h0, sg, 15'h0};
                1: r = {16'h0, sg, 5'h0, r[9:1], 1'b1};
                2: r = {16'h0, sg, 5'h1F, 10'h0};
                3: r = {16'h0, sg, 5'h1F, 1'b1, r[8:0]};
                4: r = {16'h0, sg, 5'h1F, 1'b0, r[8:1], 1'b1};
                default: r = {16'h0, r[15:0]};
            endcase
        end else begin
            case (k)
                0: r = {sg, 31'h0};
                1: r = {sg, 8'h0, r[22:1], 1'b1};
                2: r = {sg, 8'hFF, 23'h0};
                3: r = {sg, 8'hFF, 1'b1, r[21:0]};
                4: r = {sg, 8'hFF, 1'b0, r[21:1], 1'b1};
                default: r = r;
            endcase
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_src(input logic md);
        logic [VW-1:0] v;
        logic [31:0] t;
        for (int i = 0; i < VW / 16; i++) begin
            if (!md) begin
                t = pick(1'b0);
                v[16*i +: 16] = t[15:0];
            end else if (i % 2 == 0) begin
                v[32*(i/2) +: 32] = pick(1'b1);
            end
        end
        return v;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic apply(input logic md, input logic [VW-1:0] s, input logic [VW-1:0] o,
                         input logic [PW-1:0] p, input logic fz, input logic dn,
                         input logic clr, input string req);
        logic [VW-1:0] ev;
        logic ei, ed;
        @(negedge clk);
        cvt_mode = md; src_vec = s; dst_old = o; pred_mask = p;
        flush_den = fz; dflt_nan = dn; flag_clr = clr; in_valid = 1'b1;
        ev = ref_vec(md, s, o, p, fz, dn, ei, ed);
        if (clr) begin m_inv = 1'b0; m_den = 1'b0; end
        m_inv |= ei; m_den |= ed;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
        chk(req, res_vec, ev);
        chk({req, " strobe/flags"}, VW'({res_valid, flag_inv, flag_den}), VW'({1'b1, m_inv, m_den}));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [VW-1:0] s, o, held;
        logic [PW-1:0] p;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset", VW'({res_valid, flag_inv, flag_den}), '0);
        chk("R11 reset vec", res_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R1: 1.0 in odd element, signalling NaN in even element of each lane
        s = '0;
        for (int e = 0; e < VW / 32; e++) s[32*e +: 32] = {16'h3C00, 16'h7C01};
        o = rand_vec();
        apply(1'b0, s, o, '1, 1'b0, 1'b0, 1'b1, "R4 h2s normal");
        chk("R1 even ignored", VW'({res_vec[31:0], flag_inv}), VW'({32'h3F800000, 1'b0}));

        // R5: smallest half subnormal normalised
        s = '0; s[31:16] = 16'h0001;
        apply(1'b0, s, o, '1, 1'b0, 1'b0, 1'b0, "R5 subnormal");
        chk("R5 value", VW'(res_vec[31:0]), VW'(32'h33800000));

        // R6: flushed negative subnormal
        s = '0; s[31:16] = 16'h8001;
        apply(1'b0, s, o, '1, 1'b1, 1'b0, 1'b0, "R6 flush");
        chk("R6 value", VW'({res_vec[31:0], flag_den}), VW'({32'h80000000, 1'b1}));

        // R2/R7: single signalling NaN widened and quieted
        s = '0; s[63:32] = 32'h7F800001;
        apply(1'b1, s, o, '1, 1'b0, 1'b0, 1'b1, "R7 snan");
        chk("R7 value", VW'({res_vec[63:0], flag_inv}), VW'({64'h7FF8000020000000, 1'b1}));

        // R8: default NaN
        s = '0; s[63:32] = 32'hFFC00005;
        apply(1'b1, s, o, '1, 1'b0, 1'b1, 1'b1, "R8 default nan");
        chk("R8 value", VW'(res_vec[63:0]), VW'(64'h7FF8000000000000));

        // R3/R12: only non-lowest predicate bits set, snan source
        s = '0;
        for (int e = 0; e < VW / 32; e++) s[32*e +: 32] = 32'h7C017C01;
        o = rand_vec();
        apply(1'b0, s, o, 16'hEEEE, 1'b1, 1'b0, 1'b1, "R12 no active lane");
        chk("R3 inactive keeps old", res_vec, o);

        // R10: result held while idle
        held = res_vec;
        @(negedge clk);
        src_vec = rand_vec(); dst_old = rand_vec(); pred_mask = '1;
        repeat (3) @(negedge clk);
        chk("R10 hold", VW'({res_valid, res_vec}), VW'({1'b0, held}));

        // R9: flags set then cleared without a vector
        s = '0; s[31:16] = 16'h7C01;
        apply(1'b0, s, o, 16'h0001, 1'b0, 1'b0, 1'b0, "R9 raise");
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        m_inv = 1'b0; m_den = 1'b0;
        chk("R9 clear", VW'({flag_inv, flag_den}), '0);

        // R2/R3/R9: constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic md;
            md = 1'($urandom);
            p  = PW'($urandom);
            apply(md, rand_src(md), rand_vec(), p, 1'($urandom), 1'(($urandom % 4) == 0),
                  1'(($urandom % 8) == 0), md ? "R2 s2d random" : "R9 h2s random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule